// File: doc/BRIEF.md
# Burst Address Counter Register

This block is the address source of one memory port. On every rising clock edge it chooses one of four actions for its stored address: clear it to zero, load an address presented from outside, step it up by one, or keep it. The stored address is the address the port uses for its array access in the cycle after that edge, so a host can start a burst with a single loaded address and then let the counter walk through consecutive locations, or pause the walk without losing its place.

Three active-low controls pick the action with a fixed priority: clear beats load, load beats step, and with none of them asserted the address holds. None of the three is gated by the port's chip enables: a deselected port still clears, loads and steps. Alongside the address the block registers the combined chip-enable condition, so the address and the "this cycle is a real access" flag leave the block aligned to the same edge.

Clearing costs no dead cycle: the cycle right after a clear edge already addresses location zero. The counter wraps from its all-ones value to zero.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `rst` is high at a rising edge, `acc_addr` becomes 0 and `port_active` becomes 0 at that edge.
- R2: With `clear_n` low at an edge, `acc_addr` is 0 after that edge, whatever `load_n`, `advance_n` and `ext_addr` are.
- R3: With `clear_n` high and `load_n` low at an edge, `acc_addr` after that edge equals `ext_addr` sampled at that edge, whatever `advance_n` is.
- R4: With `clear_n` and `load_n` high and `advance_n` low at an edge, `acc_addr` becomes its previous value plus one.
- R5: With all three controls high at an edge, `acc_addr` keeps its previous value.
- R6: Stepping from the all-ones address (2^ADDR_W - 1) gives address 0.
- R7: Chip enables have no effect on the address: clear, load, step and hold behave as in R2 to R5 while the port is deselected (`ce_lo_n` high or `ce_hi` low).
- R8: `port_active` after an edge is 1 exactly when `ce_lo_n` was low and `ce_hi` was high at that edge.
- R9: Holding `load_n` low on consecutive edges loads each new `ext_addr` in turn, with no requirement that they be sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clear_n | input | 1 | Force address to zero, active low, highest priority |
| load_n | input | 1 | Load `ext_addr`, active low |
| advance_n | input | 1 | Step address by one, active low |
| ext_addr | input | ADDR_W | Externally supplied address |
| ce_lo_n | input | 1 | Chip enable, active low |
| ce_hi | input | 1 | Chip enable, active high |
| acc_addr | output | ADDR_W | Registered address for the current access |
| port_active | output | 1 | Registered "port selected" flag for the current access |

## Verification
The controls that can collide in one edge are clear, load and step, and any of them can coincide with a deselected port. The bench drives random combinations of all three controls and both chip enables every cycle, so clear-with-load, load-with-step and step-while-deselected all arise, and each result is judged against a bench model that applies the stated priority. Directed cases pin the wrap from all-ones, an access at zero in the cycle right after a clear, and back-to-back unrelated loads.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } addr_op_e;

endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
    import burst_addr_pkg::*;
(
    input  logic     clear_n,
    input  logic     load_n,
    input  logic     advance_n,
    output addr_op_e op
);
    // Fixed priority: clear, then load, then step, else hold.
    always_comb begin
        if (!clear_n)        op = OP_CLEAR;
        else if (!load_n)    op = OP_LOAD;
        else if (!advance_n) op = OP_STEP;
        else                 op = OP_HOLD;
    end
endmodule

// File: rtl/burst_addr_next.sv
module burst_addr_next
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  addr_op_e          op,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] ext,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ZERO = '0;

    // Step result is modulo 2^ADDR_W, so all-ones wraps to zero.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = ZERO;
            OP_LOAD:  nxt = ext;
            OP_STEP:  nxt = cur + ONE;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_n,
    input  logic              load_n,
    input  logic              advance_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ce_lo_n,
    input  logic              ce_hi,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              port_active
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              active;
    } ctr_state_t;

    ctr_state_t        st_d, st_q;
    addr_op_e          op;
    logic [ADDR_W-1:0] addr_nxt;

    burst_op_decode u_dec (
        .clear_n   (clear_n),
        .load_n    (load_n),
        .advance_n (advance_n),
        .op        (op)
    );

    burst_addr_next #(.ADDR_W(ADDR_W)) u_nxt (
        .op  (op),
        .cur (st_q.addr),
        .ext (ext_addr),
        .nxt (addr_nxt)
    );

    // Chip enables only feed the active flag; the address path never sees them.
    always_comb begin
        st_d        = st_q;
        st_d.addr   = addr_nxt;
        st_d.active = !ce_lo_n && ce_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_addr    = st_q.addr;
    assign port_active = st_q.active;
endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              clear_n,
    input logic              load_n,
    input logic              advance_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ce_lo_n,
    input logic              ce_hi,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              port_active
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (acc_addr == '0) && !port_active);

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> acc_addr == '0);

    a_r3_load_ext: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !load_n) |=> acc_addr == $past(ext_addr));

    a_r4_step_up: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && !advance_n) |=> acc_addr == ADDR_W'($past(acc_addr) + 1'b1));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && advance_n) |=> $stable(acc_addr));

    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && !advance_n && (&acc_addr)) |=> acc_addr == '0);

    a_r8_active_flag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> port_active == $past(!ce_lo_n && ce_hi));
endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clear_n     (clear_n),
    .load_n      (load_n),
    .advance_n   (advance_n),
    .ext_addr    (ext_addr),
    .ce_lo_n     (ce_lo_n),
    .ce_hi       (ce_hi),
    .acc_addr    (acc_addr),
    .port_active (port_active)
);

// File: tb/burst_addr_ctr_test.sv
module burst_addr_ctr_test;
    localparam int ADDR_W = 16;
    localparam logic [ADDR_W-1:0] ALL1 = '1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clear_n = 1'b1, load_n = 1'b1, advance_n = 1'b1;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic              ce_lo_n = 1'b1, ce_hi = 1'b0;
    logic [ADDR_W-1:0] acc_addr;
    logic              port_active;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [ADDR_W-1:0] exp_addr = '0;

    always #2 clk = ~clk;

    burst_addr_ctr #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .clear_n(clear_n), .load_n(load_n),
        .advance_n(advance_n), .ext_addr(ext_addr), .ce_lo_n(ce_lo_n),
        .ce_hi(ce_hi), .acc_addr(acc_addr), .port_active(port_active)
    );

    function automatic logic [ADDR_W-1:0] model_next(
        logic [ADDR_W-1:0] cur, logic c_n, logic l_n, logic a_n, logic [ADDR_W-1:0] ext);
        if (!c_n)      return '0;
        else if (!l_n) return ext;
        else if (!a_n) return cur + 1'b1;
        else           return cur;
    endfunction

    function automatic string op_tag(logic c_n, logic l_n, logic a_n, logic sel);
        string s;
        if (!c_n)      s = "R2";
        else if (!l_n) s = "R3";
        else if (!a_n) s = "R4";
        else           s = "R5";
        if (!sel) s = {s, "/R7"};
        return s;
    endfunction

    task automatic show_summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic check_addr(string tag, logic [ADDR_W-1:0] exp);
        n_vec++;
        if (acc_addr !== exp) begin
            n_bad++;
            $display("FAIL %s addr actual=%h expected=%h", tag, acc_addr, exp);
        end
    endtask

    task automatic check_act(string tag, logic exp);
        n_vec++;
        if (port_active !== exp) begin
            n_bad++;
            $display("FAIL %s active actual=%b expected=%b", tag, port_active, exp);
        end
    endtask

    // Inputs change at negedge; outputs compared at the following negedge.
    task automatic step(logic c_n, logic l_n, logic a_n, logic [ADDR_W-1:0] ext,
                        logic e_lo_n, logic e_hi, string tag);
        logic sel;
        clear_n = c_n; load_n = l_n; advance_n = a_n; ext_addr = ext;
        ce_lo_n = e_lo_n; ce_hi = e_hi;
        sel = !e_lo_n && e_hi;
        exp_addr = model_next(exp_addr, c_n, l_n, a_n, ext);
        @(posedge clk);
        @(negedge clk);
        check_addr(tag, exp_addr);
        check_act("R8", sel);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            show_summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5713));
        clear_n = 1'b0; load_n = 1'b0; advance_n = 1'b0; ext_addr = 16'h1234;
        ce_lo_n = 1'b0; ce_hi = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_addr("R1", '0);
        check_act("R1", 1'b0);
        rst = 1'b0;
        exp_addr = '0;

        // Directed corner cases
        step(1, 0, 1, 16'h00A5, 0, 1, "R3");
        step(1, 0, 0, 16'h3C00, 0, 1, "R3 load over step");
        step(1, 1, 0, 16'hFFFF, 0, 1, "R4");
        step(1, 1, 1, 16'h0000, 0, 1, "R5");
        step(0, 0, 0, 16'h7777, 0, 1, "R2 clear over load+step");
        step(1, 1, 0, 16'h0000, 0, 1, "R4 after clear");
        step(1, 0, 1, ALL1,     0, 1, "R3");
        step(1, 1, 0, 16'h0000, 0, 1, "R6 wrap");
        step(1, 1, 0, 16'h0000, 1, 1, "R7 step deselected");
        step(1, 0, 1, 16'h4321, 0, 0, "R7 load deselected");
        step(0, 1, 1, 16'h0000, 1, 0, "R7 clear deselected");
        step(1, 1, 1, 16'h0000, 1, 1, "R7 hold deselected");
        step(1, 0, 1, 16'h9001, 0, 1, "R9");
        step(1, 0, 1, 16'h0042, 0, 1, "R9");
        step(1, 0, 1, 16'hE00E, 0, 1, "R9");

        // Random mix of all controls and enables
        for (int i = 0; i < 3000; i++) begin
            logic c_n, l_n, a_n, e_lo_n, e_hi;
            logic [ADDR_W-1:0] ext;
            c_n    = ($urandom % 8) != 0;
            l_n    = ($urandom % 3) != 0;
            a_n    = ($urandom % 2) != 0;
            e_lo_n = ($urandom % 4) == 0;
            e_hi   = ($urandom % 4) != 0;
            ext    = (($urandom % 5) == 0) ? (ALL1 - ADDR_W'($urandom % 3))
                                           : ADDR_W'($urandom);
            step(c_n, l_n, a_n, ext, e_lo_n, e_hi, op_tag(c_n, l_n, a_n, !e_lo_n && e_hi));
        end

        show_summary();
        $finish;
    end
endmodule